// File: doc/BRIEF.md
# Serial Receive FIFO with Trigger and Flow-Control Flags

This block is the receive half of a serial port, placed after the bit-level deserialiser. Received bytes arrive on a valid/data pair and are queued in a 16-entry first-in first-out buffer. A host drains them through a small register port. Reading the data register removes the oldest byte. Two status flags tell the host how full the queue is. One says the programmable trigger level has been reached. The other says some bytes are waiting but fewer than that level.

A control register holds two selectors. The first picks the trigger level. The second picks an acceptance threshold that drives a ready output back to the sender. That output is advisory flow control. The queue still stores any byte that finds a free slot. A byte that arrives with all 16 slots taken is discarded, and a sticky overrun bit is raised in a line status register. Reading that register clears the bit.

Register map on `regAddr`: 0 is data (a read pops a byte), 1 is status (read only), 2 is line status (clear on read), and 3 is control (read/write). Writes go only to address 3. Writes to any other address have no effect.

Top module: `serial_rx_fifo`

## Requirements
- R1: After reset the status register reads 0x0060, the line status register reads 0, the control register reads 0, the queue is empty and `rxReady` is 1.
- R2: Bytes are returned in arrival order, one per data-register read, over any number of pointer wrap-arounds; the data read value is the byte in bits [7:0] and zero above.
- R3: With 16 bytes stored and no pop in that cycle, an arriving byte is discarded, the stored bytes are left unchanged, and line status bit 0 (overrun) becomes 1.
- R4: When a push and a data-register pop happen in the same cycle with the queue full, the new byte is stored and no overrun is flagged.
- R5: Control bits [7:6] select the trigger level: code 0 gives 1, 1 gives 4, 2 gives 8 and 3 gives 14 bytes. Status bit 1 (trigger reached) is 1 exactly when the byte count is at or above that level.
- R6: Status bit 0 (data waiting) is 1 exactly when the count is non-zero and below the trigger level. The two flags are never both 1. Status bits 5 and 6 always read 1, and every other bit reads 0.
- R7: Control bits [10:8] select the acceptance threshold: codes 0 to 7 give 15, 1, 4, 6, 8, 10, 12 and 14 bytes. `rxReady` is 1 exactly when the count is below that threshold.
- R8: A read of line status returns its current value and clears it in that cycle. An overrun in the same cycle leaves the bit set.
- R9: A data-register read of an empty queue returns 0 and leaves the count, the flags and the line status unchanged.
- R10: The control register reads back all 16 bits as last written. Writes to addresses 0, 1 and 2 change no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| rxValid | input | 1 | Upstream byte present this cycle |
| rxData | input | 8 | Upstream byte |
| rxReady | output | 1 | Flow control: more bytes welcome |
| regRd | input | 1 | Host read strobe, side effects at the clock edge |
| regWr | input | 1 | Host write strobe |
| regAddr | input | 2 | Register select |
| regWdata | input | 16 | Host write data |
| regRdata | output | 16 | Host read data, combinational from current state and address |

## Verification
The bench goes after the boundaries of the count.

Overflow at exactly 16 is checked: a design that wrote into the full queue would corrupt the oldest byte, and the drain order would show it. The full queue with a simultaneous pop is checked: a design that ordered the full test before the pop would raise a false overrun and lose the byte. A pop of an empty queue is checked: a design that moved its pointers there would return stale data later.

Every trigger code and every threshold code is swept. A design with an off-by-one comparison would move a flag or `rxReady` one byte early or late.

A line-status read that coincides with an overrun is checked: a design where the clear takes priority would drop the event. Long random traffic mixes pushes, pops, status reads and control writes across many pointer wraps, and compares every read against a queue model.

// File: rtl/srf_pkg.sv
package srf_pkg;

  localparam logic [1:0] ADDR_DATA = 2'd0;
  localparam logic [1:0] ADDR_STAT = 2'd1;
  localparam logic [1:0] ADDR_LINE = 2'd2;
  localparam logic [1:0] ADDR_CTRL = 2'd3;

  // control field positions decoded by the control module
  localparam int TRIG_LSB = 6;
  localparam int TRIG_W   = 2;
  localparam int ACC_LSB  = 8;
  localparam int ACC_W    = 3;

  // status bit positions
  localparam int STAT_WAIT = 0;
  localparam int STAT_TRIG = 1;
  localparam int STAT_ONE0 = 5;
  localparam int STAT_ONE1 = 6;

  localparam int LINE_OVR = 0;

  typedef struct packed {
    logic pushEn;
    logic popEn;
  } fifoStrobeT;

  function automatic int unsigned triggerLevel(input logic [TRIG_W-1:0] sel);
    case (sel)
      2'd0:    return 1;
      2'd1:    return 4;
      2'd2:    return 8;
      default: return 14;
    endcase
  endfunction

  function automatic int unsigned acceptLevel(input logic [ACC_W-1:0] sel);
    // code 0 is the widest threshold, codes 1..7 step up from one byte
    if (sel == 3'd0) return 15;
    if (sel == 3'd1) return 1;
    return 2 * int'(sel);
  endfunction

endpackage

// File: rtl/srf_datapath.sv
module srf_datapath
  import srf_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 16,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = PTR_W + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  fifoStrobeT        strobe,
  input  logic [DATA_W-1:0] pushData,
  output logic [CNT_W-1:0]  count,
  output logic [DATA_W-1:0] headData
);

  localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(DEPTH - 1);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

  logic [DATA_W-1:0] store [DEPTH];
  logic [PTR_W-1:0]  wrPtr, rdPtr;

  function automatic logic [PTR_W-1:0] bumpPtr(input logic [PTR_W-1:0] p);
    return (p == LAST_PTR) ? '0 : p + PTR_W'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (strobe.pushEn) store[wrPtr] <= pushData;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (strobe.pushEn) wrPtr <= bumpPtr(wrPtr);
      if (strobe.popEn)  rdPtr <= bumpPtr(rdPtr);
      case ({strobe.pushEn, strobe.popEn})
        2'b10:   count <= count + CNT_W'(1);
        2'b01:   count <= count - CNT_W'(1);
        default: count <= count;
      endcase
    end
  end

  assign headData = store[rdPtr];

  assert_count_bound_R3: assert property (@(posedge clk) disable iff (!rstN)
    count <= FULL_CNT);

  assert_no_push_full_R3: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.pushEn && !strobe.popEn) |-> (count < FULL_CNT));

  assert_no_pop_empty_R9: assert property (@(posedge clk) disable iff (!rstN)
    strobe.popEn |-> (count != '0));

  assert_push_grows_R2: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.pushEn && !strobe.popEn) |=> (count == $past(count) + CNT_W'(1)));

  assert_swap_keeps_R4: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.pushEn && strobe.popEn) |=> $stable(count));

endmodule

// File: rtl/srf_control.sv
module srf_control
  import srf_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 16,
  parameter int REG_W  = 16,
  localparam int CNT_W = $clog2(DEPTH) + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              rxValid,
  input  logic              regRd,
  input  logic              regWr,
  input  logic [1:0]        regAddr,
  input  logic [REG_W-1:0]  regWdata,
  input  logic [CNT_W-1:0]  count,
  input  logic [DATA_W-1:0] headData,
  output fifoStrobeT        strobe,
  output logic              rxReady,
  output logic [REG_W-1:0]  regRdata
);

  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

  logic [REG_W-1:0]  ctrlReg;
  logic              overrun;
  logic [CNT_W-1:0]  trigLvl, accLvl;
  logic              trigHit, dataWait;
  logic              isEmpty, isFull;
  logic              dataRead, lineRead, overEvt;
  logic [REG_W-1:0]  statWord;

  assign trigLvl = CNT_W'(triggerLevel(ctrlReg[TRIG_LSB +: TRIG_W]));
  assign accLvl  = CNT_W'(acceptLevel(ctrlReg[ACC_LSB +: ACC_W]));

  assign isEmpty  = (count == '0);
  assign isFull   = (count == FULL_CNT);
  assign dataRead = regRd && (regAddr == ADDR_DATA);
  assign lineRead = regRd && (regAddr == ADDR_LINE);

  // strobes toward the datapath
  assign strobe.popEn  = dataRead && !isEmpty;
  assign strobe.pushEn = rxValid && (!isFull || strobe.popEn);
  assign overEvt       = rxValid && isFull && !strobe.popEn;

  // fill-level flags follow the current count
  assign trigHit  = (count >= trigLvl);
  assign dataWait = !trigHit && !isEmpty;
  assign rxReady  = (count < accLvl);

  always_comb begin
    statWord            = '0;
    statWord[STAT_WAIT] = dataWait;
    statWord[STAT_TRIG] = trigHit;
    statWord[STAT_ONE0] = 1'b1;
    statWord[STAT_ONE1] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctrlReg <= '0;
      overrun <= 1'b0;
    end else begin
      if (regWr && (regAddr == ADDR_CTRL)) ctrlReg <= regWdata;
      if (overEvt)       overrun <= 1'b1;
      else if (lineRead) overrun <= 1'b0;
    end
  end

  always_comb begin
    regRdata = '0;
    case (regAddr)
      ADDR_DATA: if (!isEmpty) regRdata[DATA_W-1:0] = headData;
      ADDR_STAT: regRdata = statWord;
      ADDR_LINE: regRdata[LINE_OVR] = overrun;
      default:   regRdata = ctrlReg;
    endcase
  end

  assert_flags_excl_R6: assert property (@(posedge clk) disable iff (!rstN)
    !(regRdata[STAT_WAIT] && regRdata[STAT_TRIG] && regAddr == ADDR_STAT));

  assert_overrun_set_R3: assert property (@(posedge clk) disable iff (!rstN)
    (rxValid && isFull && !dataRead) |=> overrun);

  assert_line_clear_R8: assert property (@(posedge clk) disable iff (!rstN)
    (lineRead && !rxValid) |=> !overrun);

  assert_empty_read_R9: assert property (@(posedge clk) disable iff (!rstN)
    (dataRead && isEmpty) |-> (regRdata == '0));

  assert_ctrl_hold_R10: assert property (@(posedge clk) disable iff (!rstN)
    !(regWr && regAddr == ADDR_CTRL) |=> $stable(ctrlReg));

endmodule

// File: rtl/serial_rx_fifo.sv
module serial_rx_fifo
  import srf_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 16,
  parameter int REG_W  = 16,
  localparam int CNT_W = $clog2(DEPTH) + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              rxValid,
  input  logic [DATA_W-1:0] rxData,
  output logic              rxReady,
  input  logic              regRd,
  input  logic              regWr,
  input  logic [1:0]        regAddr,
  input  logic [REG_W-1:0]  regWdata,
  output logic [REG_W-1:0]  regRdata
);

  fifoStrobeT        strobe;
  logic [CNT_W-1:0]  count;
  logic [DATA_W-1:0] headData;

  srf_control #(.DATA_W(DATA_W), .DEPTH(DEPTH), .REG_W(REG_W)) uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .rxValid  (rxValid),
    .regRd    (regRd),
    .regWr    (regWr),
    .regAddr  (regAddr),
    .regWdata (regWdata),
    .count    (count),
    .headData (headData),
    .strobe   (strobe),
    .rxReady  (rxReady),
    .regRdata (regRdata)
  );

  srf_datapath #(.DATA_W(DATA_W), .DEPTH(DEPTH)) uData (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .pushData (rxData),
    .count    (count),
    .headData (headData)
  );

endmodule

// File: tb/tb_serial_rx_fifo.sv
module tb_serial_rx_fifo;

  logic        clk = 1'b0;
  logic        rstN;
  logic        rxValid;
  logic [7:0]  rxData;
  logic        rxReady;
  logic        regRd, regWr;
  logic [1:0]  regAddr;
  logic [15:0] regWdata;
  logic [15:0] regRdata;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  logic [7:0]  q[$];
  logic [15:0] ctrlM = '0;
  logic        lsrM  = 1'b0;

  always #5 clk = ~clk;

  serial_rx_fifo dut (
    .clk(clk), .rstN(rstN), .rxValid(rxValid), .rxData(rxData), .rxReady(rxReady),
    .regRd(regRd), .regWr(regWr), .regAddr(regAddr), .regWdata(regWdata),
    .regRdata(regRdata)
  );

  function automatic int trigOf(input logic [15:0] c);
    case (c[7:6]) 2'd0: return 1; 2'd1: return 4; 2'd2: return 8; default: return 14; endcase
  endfunction

  function automatic int accOf(input logic [15:0] c);
    case (c[10:8])
      3'd0: return 15; 3'd1: return 1; 3'd2: return 4; 3'd3: return 6;
      3'd4: return 8;  3'd5: return 10; 3'd6: return 12; default: return 14;
    endcase
  endfunction

  function automatic logic [15:0] statOf(input int n, input logic [15:0] c);
    logic [15:0] s = 16'h0060;
    if (n >= trigOf(c)) s[1] = 1'b1;
    else if (n > 0) s[0] = 1'b1;
    return s;
  endfunction

  function automatic logic [15:0] readOf(input logic [1:0] a);
    case (a)
      2'd0: return (q.size() > 0) ? {8'h00, q[0]} : 16'h0000;
      2'd1: return statOf(q.size(), ctrlM);
      2'd2: return {15'd0, lsrM};
      default: return ctrlM;
    endcase
  endfunction

  task automatic check(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic step(input bit doPush, input logic [7:0] pd, input bit doRd, input bit doWr,
                      input logic [1:0] ad, input logic [15:0] wd, input string tag);
    bit pop;
    logic [15:0] exp;
    string t;
    @(negedge clk);
    rxValid = doPush; rxData = pd; regRd = doRd; regWr = doWr; regAddr = ad; regWdata = wd;
    #1;
    check(rxReady == (q.size() < accOf(ctrlM)), "R7 rxReady", {15'd0, rxReady},
          {15'd0, q.size() < accOf(ctrlM)});
    if (doRd) begin
      exp = readOf(ad);
      if (tag != "") t = tag;
      else case (ad) 2'd0: t = "R2 data"; 2'd1: t = "R5 R6 status"; 2'd2: t = "R8 line"; default: t = "R10 ctrl"; endcase
      check(regRdata == exp, t, regRdata, exp);
    end
    pop = doRd && ad == 2'd0 && q.size() > 0;
    if (doRd && ad == 2'd2) lsrM = 1'b0;
    if (pop) void'(q.pop_front());
    if (doPush) begin
      if (q.size() < 16) q.push_back(pd);
      else lsrM = 1'b1;
    end
    if (doWr && ad == 2'd3) ctrlM = wd;
    @(posedge clk);
  endtask

  task automatic idle();
    @(negedge clk);
    rxValid = 0; regRd = 0; regWr = 0;
  endtask

  task automatic push(input logic [7:0] d);
    step(1, d, 0, 0, 2'd0, 16'h0, "");
  endtask

  task automatic rd(input logic [1:0] a, input string tag);
    step(0, 8'h00, 1, 0, a, 16'h0, tag);
  endtask

  task automatic wrCtrl(input logic [15:0] v);
    step(0, 8'h00, 0, 1, 2'd3, v, "");
  endtask

  task automatic drain(input string tag);
    while (q.size() > 0) rd(2'd0, tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    rstN = 0; rxValid = 0; rxData = 0; regRd = 0; regWr = 0; regAddr = 0; regWdata = 0;
    repeat (4) @(posedge clk);
    @(negedge clk); rstN = 1;

    // R1 reset values
    rd(2'd1, "R1 status reset");
    rd(2'd2, "R1 line reset");
    rd(2'd3, "R1 ctrl reset");
    rd(2'd0, "R1 data reset");

    // R9 pop from empty leaves state unchanged
    rd(2'd0, "R9 empty pop");
    rd(2'd1, "R9 status after empty pop");
    rd(2'd2, "R9 line after empty pop");

    // R10 writes to other addresses are ignored
    step(0, 0, 0, 1, 2'd1, 16'hFFFF, "");
    step(0, 0, 0, 1, 2'd2, 16'hFFFF, "");
    step(0, 0, 0, 1, 2'd0, 16'hFFFF, "");
    rd(2'd1, "R10 status after stray write");
    rd(2'd2, "R10 line after stray write");
    rd(2'd3, "R10 ctrl after stray write");
    rd(2'd0, "R10 data after stray write");
    wrCtrl(16'hA5C3);
    rd(2'd3, "R10 ctrl readback");
    wrCtrl(16'h0000);

    // R3 overflow at 16
    for (int i = 0; i < 16; i++) push(8'h30 + 8'(i));
    rd(2'd2, "R3 line before overflow");
    push(8'hEE);
    rd(2'd2, "R3 overrun flagged");
    rd(2'd2, "R8 cleared after read");
    drain("R3 contents after overflow");

    // R4 full with simultaneous pop and push
    for (int i = 0; i < 16; i++) push(8'h50 + 8'(i));
    step(1, 8'hAB, 1, 0, 2'd0, 16'h0, "R4 pop while full");
    rd(2'd2, "R4 no overrun");
    drain("R4 order after swap");

    // R8 line read coinciding with overrun
    for (int i = 0; i < 16; i++) push(8'h70 + 8'(i));
    step(1, 8'hCC, 1, 0, 2'd2, 16'h0, "R8 read during overrun");
    rd(2'd2, "R8 overrun kept");
    rd(2'd2, "R8 cleared");
    drain("R2 drain");

    // R5 R6 trigger sweep, R7 threshold sweep
    for (int tsel = 0; tsel < 4; tsel++) begin
      wrCtrl(16'(tsel) << 6);
      for (int n = 0; n <= 15; n++) begin
        rd(2'd1, "R5 R6 trigger sweep");
        push(8'(n));
      end
      drain("R2 sweep drain");
    end
    for (int asel = 0; asel < 8; asel++) begin
      wrCtrl(16'(asel) << 8);
      for (int n = 0; n < 16; n++) push(8'(n + asel));
      drain("R7 sweep drain");
    end

    // random mix
    void'($urandom(32'h5EED1234));
    for (int i = 0; i < 4000; i++) begin
      int op = int'($urandom() % 10);
      bit pu = ($urandom() % 2) == 1;
      logic [7:0] d = 8'($urandom());
      case (op)
        0, 1, 2: step(1, d, 0, 0, 2'd0, 16'h0, "");
        3, 4:    step(pu, d, 1, 0, 2'd0, 16'h0, "");
        5:       step(pu, d, 1, 0, 2'd1, 16'h0, "");
        6:       step(pu, d, 1, 0, 2'd2, 16'h0, "");
        7:       step(pu, d, 1, 0, 2'd3, 16'h0, "");
        8:       step(pu, d, 0, 1, 2'd3, 16'($urandom()), "");
        default: step(0, d, 0, 0, 2'd0, 16'h0, "");
      endcase
    end
    drain("R2 final drain");
    idle();

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule